// File: doc/BRIEF.md
# Call Return Stack With Context Save

This block is the hardware return stack of a small processor core. When the core enters a subroutine or takes an interrupt it pulses the push strobe. The block then saves a context record: the address of the instruction after the call, the global interrupt enable bit, the two-bit register bank selection and the four ALU flags. A pop strobe, issued on return, brings the most recent record back onto the restore outputs. Calls and interrupts share the one stack of twelve records.

The block also computes the call destination. In short form the low eight bits of the operand are a signed displacement, added to the next-instruction address. In long form the whole sixteen-bit operand is the absolute destination. The destination is a combinational output that is valid in the same cycle as the operand.

All pins are plain control and status pins. The core issues strobes with no handshake, and the block accepts every strobe in the cycle it arrives, so there is no back-pressure. The depth output and two sticky error flags show the stack state. Interrupt arbitration and the ALU are outside this block.

Top module: `call_ret_stack`

## Requirements
- R1: A push on a stack holding fewer than 12 records, with no pop in the same cycle, raises `depth_o` by one after the clock edge. `depth_o` never exceeds 12, and call and interrupt pushes count against the same limit.
- R2: A push stores `next_pc_i`, `gie_i`, `bank_i` and `flags_i` (bit 3 Z, bit 2 C, bit 1 N, bit 0 V) as one record. A later pop that reaches that record presents the same four values on `ret_pc_o`, `ret_gie_o`, `ret_bank_o` and `ret_flags_o` one cycle after the pop strobe.
- R3: Pops return records in last-in-first-out order. A pop on a non-empty stack with no push lowers `depth_o` by one.
- R4: With `long_call_i` low, `target_o` equals `next_pc_i` plus `operand_i[7:0]` sign-extended to 16 bits, modulo 2^16. This gives a displacement range of -128 to +127.
- R5: With `long_call_i` high, `target_o` equals `operand_i[15:0]`, so any address from 0 to 65535 can be reached.
- R6: A push when 12 records are held, with no pop in the same cycle, leaves `depth_o` at 12, overwrites no record and sets `overflow_o`.
- R7: A pop on an empty stack, with no push in the same cycle, sets `underflow_o`, leaves all four restore outputs unchanged and keeps `depth_o` at 0.
- R8: When push and pop arrive in the same cycle, the pop is handled first and the push second. On a non-empty stack the top record is delivered to the restore outputs and replaced by the new one, and depth stays the same; this also holds when the stack is full, and then no overflow is raised. On an empty stack the pop underflows and the push still stores its record, giving depth 1.
- R9: While `rst_n` is low, `depth_o` is 0, both error flags are clear and all restore outputs are zero.
- R10: `overflow_o` and `underflow_o` stay set until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Save one context record this cycle |
| pop_i | input | 1 | Restore the top context record this cycle |
| long_call_i | input | 1 | 1: absolute destination, 0: relative destination |
| operand_i | input | 16 | Call operand (displacement in bits 7:0, or absolute address) |
| next_pc_i | input | 16 | Address of the instruction after the call |
| gie_i | input | 1 | Current global interrupt enable |
| bank_i | input | 2 | Current register bank selection |
| flags_i | input | 4 | Current ALU flags {Z,C,N,V} |
| target_o | output | 16 | Computed call destination |
| ret_pc_o | output | 16 | Restored return address |
| ret_gie_o | output | 1 | Restored interrupt enable |
| ret_bank_o | output | 2 | Restored bank selection |
| ret_flags_o | output | 4 | Restored ALU flags |
| depth_o | output | 4 | Number of records held |
| overflow_o | output | 1 | Sticky: push refused on a full stack |
| underflow_o | output | 1 | Sticky: pop on an empty stack |

## Verification
The assertions assume that the strobes are clean single-cycle levels sampled at the rising edge and that reset is applied before the first strobe. They make no assumption about how often the core pushes or pops. The stimulus drives every input away from the clock edge. Random phases alternate between a push bias and a pop bias, so the stack reaches both full and empty many times. Directed sequences cover the full-stack push, the empty-stack pop and simultaneous strobes at both extremes.

// File: rtl/crs_pkg.sv
package crs_pkg;
  parameter int unsigned PC_W   = 16;
  parameter int unsigned OFS_W  = 8;
  parameter int unsigned BANK_W = 2;
  parameter int unsigned FLAG_W = 4;

  // One saved context record; flags ordered {Z,C,N,V}
  typedef struct packed {
    logic [PC_W-1:0]   pc;
    logic              gie;
    logic [BANK_W-1:0] bank;
    logic [FLAG_W-1:0] flags;
  } ctx_t;
endpackage

// File: rtl/crs_target.sv
module crs_target
  import crs_pkg::*;
(
  input  logic            long_i,
  input  logic [PC_W-1:0] operand_i,
  input  logic [PC_W-1:0] next_pc_i,
  output logic [PC_W-1:0] target_o
);
  localparam int unsigned EXT_W = PC_W - OFS_W;

  logic [PC_W-1:0] disp;
  assign disp     = {{EXT_W{operand_i[OFS_W-1]}}, operand_i[OFS_W-1:0]};
  assign target_o = long_i ? operand_i : (next_pc_i + disp);
endmodule

// File: rtl/crs_ctl.sv
module crs_ctl #(
  parameter int unsigned DEPTH = 12,
  parameter int unsigned DW    = 4,
  parameter int unsigned IW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [DW-1:0] depth_o,
  output logic          wr_en_o,
  output logic [IW-1:0] wr_idx_o,
  output logic          rd_en_o,
  output logic [IW-1:0] rd_idx_o,
  output logic          ovf_o,
  output logic          udf_o
);
  logic [DW-1:0] depth_q;
  logic [DW-1:0] depth_mid;
  logic          pop_ok, pop_bad, push_ok, push_bad;

  always_comb begin
    pop_ok    = pop_i && (depth_q != '0);
    pop_bad   = pop_i && (depth_q == '0);
    // pop is applied before push in the same cycle
    depth_mid = depth_q - DW'(pop_ok);
    push_ok   = push_i && (depth_mid < DW'(DEPTH));
    push_bad  = push_i && !push_ok;
  end

  assign wr_en_o  = push_ok;
  assign wr_idx_o = IW'(depth_mid);
  assign rd_en_o  = pop_ok;
  assign rd_idx_o = IW'(depth_q - DW'(1));
  assign depth_o  = depth_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
      ovf_o   <= 1'b0;
      udf_o   <= 1'b0;
    end else begin
      depth_q <= depth_mid + DW'(push_ok);
      if (push_bad) ovf_o <= 1'b1;
      if (pop_bad)  udf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/crs_store.sv
module crs_store
  import crs_pkg::*;
#(
  parameter int unsigned DEPTH = 12,
  parameter int unsigned IW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  ctx_t          wr_data_i,
  input  logic          rd_en_i,
  input  logic [IW-1:0] rd_idx_i,
  output ctx_t          ret_o
);
  ctx_t slot [DEPTH];
  ctx_t rd_data;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot[g] <= '0;
      else if (wr_en_i && (wr_idx_i == IW'(g)))
        slot[g] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rd_idx_i == IW'(i)) rd_data = slot[i];
  end

  // Read sees the slot value before any same-cycle write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ret_o <= '0;
    else if (rd_en_i) ret_o <= rd_data;
  end
endmodule

// File: rtl/call_ret_stack.sv
module call_ret_stack
  import crs_pkg::*;
#(
  parameter int unsigned DEPTH = 12,
  localparam int unsigned DW   = $clog2(DEPTH + 1),
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              long_call_i,
  input  logic [PC_W-1:0]   operand_i,
  input  logic [PC_W-1:0]   next_pc_i,
  input  logic              gie_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [PC_W-1:0]   target_o,
  output logic [PC_W-1:0]   ret_pc_o,
  output logic              ret_gie_o,
  output logic [BANK_W-1:0] ret_bank_o,
  output logic [FLAG_W-1:0] ret_flags_o,
  output logic [DW-1:0]     depth_o,
  output logic              overflow_o,
  output logic              underflow_o
);
  logic          wr_en, rd_en;
  logic [IW-1:0] wr_idx, rd_idx;
  ctx_t          wr_ctx, ret_ctx;

  assign wr_ctx = '{pc: next_pc_i, gie: gie_i, bank: bank_i, flags: flags_i};

  crs_target u_target (
    .long_i    (long_call_i),
    .operand_i (operand_i),
    .next_pc_i (next_pc_i),
    .target_o  (target_o)
  );

  crs_ctl #(.DEPTH(DEPTH), .DW(DW), .IW(IW)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_i   (push_i),
    .pop_i    (pop_i),
    .depth_o  (depth_o),
    .wr_en_o  (wr_en),
    .wr_idx_o (wr_idx),
    .rd_en_o  (rd_en),
    .rd_idx_o (rd_idx),
    .ovf_o    (overflow_o),
    .udf_o    (underflow_o)
  );

  crs_store #(.DEPTH(DEPTH), .IW(IW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_ctx),
    .rd_en_i   (rd_en),
    .rd_idx_i  (rd_idx),
    .ret_o     (ret_ctx)
  );

  assign ret_pc_o    = ret_ctx.pc;
  assign ret_gie_o   = ret_ctx.gie;
  assign ret_bank_o  = ret_ctx.bank;
  assign ret_flags_o = ret_ctx.flags;
endmodule

// File: rtl/crs_checker.sv
module crs_checker #(
  parameter int unsigned DEPTH = 12,
  parameter int unsigned DW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_i,
  input logic          pop_i,
  input logic [15:0]   ret_pc_o,
  input logic [DW-1:0] depth_o,
  input logic          overflow_o,
  input logic          underflow_o
);
  a_r1_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    depth_o <= DW'(DEPTH));

  a_r1_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && depth_o < DW'(DEPTH)) |=> depth_o == $past(depth_o) + DW'(1));

  a_r3_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && depth_o != '0) |=> depth_o == $past(depth_o) - DW'(1));

  a_r6_no_overflow_write: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && depth_o == DW'(DEPTH)) |=> overflow_o && $stable(depth_o));

  a_r7_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && depth_o == '0) |=> underflow_o && $stable(ret_pc_o) && depth_o == '0);

  a_r8_swap_depth: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && depth_o != '0) |=> $stable(depth_o) && !$rose(overflow_o));

  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);

  a_r10_udf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |=> underflow_o);
endmodule

bind call_ret_stack crs_checker #(.DEPTH(DEPTH), .DW(DW)) u_crs_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .ret_pc_o    (ret_pc_o),
  .depth_o     (depth_o),
  .overflow_o  (overflow_o),
  .underflow_o (underflow_o)
);

// File: tb/test_call_ret_stack.sv
module test_call_ret_stack;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_i = 0, pop_i = 0, long_call_i = 0, gie_i = 0;
  logic [15:0] operand_i = '0, next_pc_i = '0;
  logic [1:0] bank_i = '0;
  logic [3:0] flags_i = '0;
  logic [15:0] target_o, ret_pc_o;
  logic ret_gie_o;
  logic [1:0] ret_bank_o;
  logic [3:0] ret_flags_o, depth_o;
  logic overflow_o, underflow_o;

  int checks = 0;
  int errors = 0;
  logic [22:0] m_stk [DEPTH];
  int m_depth = 0;
  logic [22:0] m_ret = '0;
  logic m_ovf = 0, m_udf = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  call_ret_stack i_call_ret_stack (.*);

  function automatic logic [15:0] exp_target(logic lng, logic [15:0] op, logic [15:0] pc);
    return lng ? op : pc + {{8{op[7]}}, op[7:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_state(string req);
    chk({req, " depth"}, 32'(depth_o), 32'(m_depth));
    chk({req, " restore"}, 32'({ret_pc_o, ret_gie_o, ret_bank_o, ret_flags_o}), 32'(m_ret));
    chk({req, " overflow R10"}, 32'(overflow_o), 32'(m_ovf));
    chk({req, " underflow R10"}, 32'(underflow_o), 32'(m_udf));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; push_i = 0; pop_i = 0;
    repeat (2) @(negedge clk);
    m_depth = 0; m_ret = '0; m_ovf = 0; m_udf = 0;
    check_state("R9");
    rst_n = 1;
  endtask

  task automatic step(string req, logic ph, logic pp, logic lng, logic [15:0] op,
                      logic [15:0] pc, logic g, logic [1:0] b, logic [3:0] f);
    @(negedge clk);
    push_i = ph; pop_i = pp; long_call_i = lng; operand_i = op;
    next_pc_i = pc; gie_i = g; bank_i = b; flags_i = f;
    #1;
    chk(lng ? "R5 target" : "R4 target", 32'(target_o), 32'(exp_target(lng, op, pc)));
    if (pp) begin
      if (m_depth == 0) m_udf = 1;
      else begin m_depth--; m_ret = m_stk[m_depth]; end
    end
    if (ph) begin
      if (m_depth < DEPTH) begin m_stk[m_depth] = {pc, g, b, f}; m_depth++; end
      else m_ovf = 1;
    end
    @(posedge clk);
    #1;
    check_state(req);
  endtask

  task automatic rnd_step(string req, logic ph, logic pp);
    logic [31:0] r = $urandom;
    step(req, ph, pp, r[0], 16'($urandom), 16'($urandom), r[1], r[3:2], r[7:4]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    do_reset();
    // R4 displacement extremes, R5 absolute extremes
    step("R4", 0, 0, 0, 16'h007F, 16'hFFF0, 0, 0, 0);
    step("R4", 0, 0, 0, 16'h0080, 16'h0010, 0, 0, 0);
    step("R5", 0, 0, 1, 16'hFFFF, 16'h1234, 0, 0, 0);
    step("R5", 0, 0, 1, 16'h0000, 16'h1234, 0, 0, 0);
    // R7 pop on empty
    step("R7", 0, 1, 0, 0, 0, 0, 0, 0);
    // R8 simultaneous on empty: underflow then one record stored
    step("R8", 1, 1, 0, 0, 16'hA5A5, 1, 2'd2, 4'hC);
    step("R3", 0, 1, 0, 0, 0, 0, 0, 0);
    do_reset();
    // R1 fill, R2 stored context
    for (int i = 0; i < DEPTH; i++)
      step("R1", 1, 0, i[0], 16'(i * 3), 16'(16'h100 + i), i[1], 2'(i), 4'(i + 5));
    // R6 push when full
    step("R6", 1, 0, 0, 0, 16'hDEAD, 1, 2'd3, 4'hF);
    // R8 simultaneous when full: swap, no new overflow
    step("R8", 1, 1, 0, 0, 16'hBEEF, 0, 2'd1, 4'h3);
    // R3 drain in LIFO order, R2 restored fields
    for (int i = 0; i < DEPTH; i++) step("R2 R3", 0, 1, 0, 0, 0, 0, 0, 0);
    step("R7", 0, 1, 0, 0, 0, 0, 0, 0);
    do_reset();
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r = $urandom;
      logic bias = ((i / 40) % 2) == 0;
      logic ph = bias ? (r[1:0] != 0) : (r[1:0] == 0);
      logic pp = bias ? (r[3:2] == 0) : (r[3:2] != 0);
      rnd_step("R2 R3 R8", ph, pp);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule